// File: doc/BRIEF.md
# Flash Programming Command Sequencer for a Scan-Port Microcontroller

This block sits on the host side of a scan (JTAG) link and drives the flash programming protocol of a small microcontroller. A client issues one high-level command at a time: read the identification word, enter programming mode, erase the whole chip, write a run of flash pages, or leave programming mode. The block expands each command into a fixed, ordered series of instruction-register and data-register shifts. It hands these shifts one at a time to a separate shift engine. That engine walks the TAP, performs the shift, and returns the captured TDO word.

Page data arrives on a byte stream with a valid/ready handshake. A write that starts inside a page is refused before any traffic is generated. A write of several pages wraps the whole run in one entry into programming mode and one exit. Erase and page commit both poll a ready flag in the captured command word. Each poll loop has a caller-supplied iteration limit, so a device that never becomes ready ends the command with an error instead of hanging the block.

Top module: `jtag_prog_seq`

## Requirements
- R1: After reset, `busy_o` is 0, `cmd_ready_o` is 1, and neither `sh_req_o` nor `byte_ready_o` is asserted. A command is taken only while `cmd_ready_o` is 1. A `cmd_valid_i` pulse during a running command has no effect and produces no shift. Op codes: 0 read ID, 1 enter, 2 erase, 3 write, 4 leave.
- R2: Once `sh_req_o` is raised, it stays high with `sh_ir_o`, `sh_len_o` and `sh_tdi_o` unchanged until the cycle in which `sh_ack_i` is 1. Every instruction shift (`sh_ir_o`=1) is 4 bits long.
- R3: Read ID shifts instruction 0x1, then a 32-bit data shift of zero. The captured word appears on `id_o`, with the part number in bits [27:12] and the revision in bits [31:28]. If bits [11:1] differ from 0x1F, `err_o` is 3.
- R4: Enter shifts instruction 0xC, then a 1-bit data value of 1, then instruction 0x4, then the 16-bit value 0xA370.
- R5: Leave shifts instruction 0x5, then the 15-bit words 0x2300 and 0x3300. It then shifts instruction 0x4 with a 16-bit zero, and finally instruction 0xC with a 1-bit zero.
- R6: Erase shifts instruction 0x5 and then the 15-bit words 0x2380, 0x3180, 0x3380 and 0x3380. It then repeats 0x3380 until bit 9 of the captured value is 1.
- R7: Each page starts with instruction 0x5, then the 15-bit words 0x2310, 0x0700 OR byte-address bits [16:9], and 0x0300 OR byte-address bits [8:1].
- R8: Page load shifts instruction 0x6 and then exactly 256 8-bit data shifts. Positions below the page's supplied byte count carry stream bytes in arrival order. The remaining positions carry 0xFF and consume nothing from the stream.
- R9: After each page load, the block shifts instruction 0x5 and the 15-bit words 0x3700, 0x3500, 0x3700 and 0x3700. It then repeats 0x3700 until captured bit 9 is 1.
- R10: A write whose offset is not a multiple of 256 issues no shift and no byte request. `done_o` pulses in the next cycle with `err_o`=1.
- R11: A write of N bytes enters programming mode once. It then writes ceil(N/256) pages at offset, offset+256 and so on, each holding min(256, remaining) supplied bytes, and leaves programming mode once.
- R12: Each poll loop issues at most max(`poll_max_i`,1) poll shifts, with the limit latched when the command is accepted. If bit 9 is still clear after the last allowed poll, the command ends with `err_o`=2 and issues no further shift.
- R13: `busy_o` stays 1 until the acknowledge of the final shift. In the next cycle `busy_o` is 0 and `done_o` is 1 for exactly one cycle. `err_o` holds its code (0 means no error) until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command op code |
| cmd_offset_i | input | 17 | Write start byte offset |
| cmd_len_i | input | 18 | Write byte count |
| poll_max_i | input | 16 | Poll iteration limit |
| cmd_ready_o | output | 1 | Idle, command can be taken |
| busy_o | output | 1 | Command running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | 0 none, 1 alignment, 2 poll timeout, 3 manufacturer mismatch |
| id_o | output | 32 | Last captured identification word |
| sh_req_o | output | 1 | Shift request to engine |
| sh_ir_o | output | 1 | 1 for instruction shift, 0 for data shift |
| sh_len_o | output | 6 | Shift length in bits |
| sh_tdi_o | output | 32 | Value shifted in |
| sh_ack_i | input | 1 | Engine completed the shift |
| sh_tdo_i | input | 32 | Captured value, valid with `sh_ack_i` |
| byte_valid_i | input | 1 | Page byte available |
| byte_data_i | input | 8 | Page byte |
| byte_ready_o | output | 1 | Page byte taken when valid |

## Verification
The hardest situations to reach are the ones in the middle of a multi-page write. These include a final partial page, where the stream stops feeding and padding takes over mid-load, and a poll loop that runs out while the device still reports busy. The bench engine model answers every shift from a scripted scoreboard entry that carries its own TDO value. This lets the script choose how many busy polls precede readiness on each page, or withhold readiness entirely. A 300-byte write therefore crosses a full page into a 44-byte page. Other runs stop the commit and erase loops at their limits. A stray command is also injected while a write is running.

// File: rtl/jps_pkg.sv
package jps_pkg;
  localparam logic [3:0] INS_ID    = 4'h1;
  localparam logic [3:0] INS_RST   = 4'hC;
  localparam logic [3:0] INS_PEN   = 4'h4;
  localparam logic [3:0] INS_PCMD  = 4'h5;
  localparam logic [3:0] INS_PLOAD = 4'h6;
  localparam logic [5:0] IR_LEN    = 6'd4;
  localparam logic [5:0] CMDW_LEN  = 6'd15;
  localparam int         READY_BIT = 9;
  localparam logic [10:0] MFG_CODE = 11'h01F;
  localparam logic [15:0] PEN_KEY  = 16'hA370;

  typedef enum logic [2:0] {
    OP_READ_ID = 3'd0, OP_ENTER = 3'd1, OP_ERASE = 3'd2, OP_WRITE = 3'd3, OP_LEAVE = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    PH_ID, PH_ENTER, PH_ERASE, PH_EPOLL, PH_WADDR, PH_WLOAD, PH_WCOMMIT, PH_WPOLL, PH_LEAVE
  } phase_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_ALIGN = 2'd1, ERR_TIMEOUT = 2'd2, ERR_MFG = 2'd3
  } err_e;

  typedef struct packed {
    logic        ir;
    logic [5:0]  len;
    logic [31:0] val;
  } step_t;

  function automatic step_t mk_ir(logic [3:0] code);
    return '{ir: 1'b1, len: IR_LEN, val: {28'd0, code}};
  endfunction

  function automatic step_t mk_dr(logic [5:0] len, logic [31:0] val);
    return '{ir: 1'b0, len: len, val: val};
  endfunction

  function automatic step_t mk_cmd(logic [14:0] word);
    return mk_dr(CMDW_LEN, {17'd0, word});
  endfunction
endpackage

// File: rtl/jps_step_rom.sv
module jps_step_rom import jps_pkg::*; #(
  parameter int ADDR_W = 17,
  parameter int IDX_W  = 9
) (
  input  phase_e             phase_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         byte_i,
  output step_t              step_o
);
  logic [2:0]  s;
  logic        first;
  logic [7:0]  addr_hi, addr_lo;

  assign s       = 3'(idx_i);
  assign first   = (idx_i == IDX_W'(0));
  assign addr_hi = 8'(addr_i >> 9);
  assign addr_lo = 8'(addr_i >> 1);

  always_comb begin
    step_o = mk_dr(6'd1, 32'd0);
    case (phase_i)
      PH_ID:    step_o = first ? mk_ir(INS_ID) : mk_dr(6'd32, 32'd0);
      PH_ENTER: case (s)
        3'd0:    step_o = mk_ir(INS_RST);
        3'd1:    step_o = mk_dr(6'd1, 32'd1);
        3'd2:    step_o = mk_ir(INS_PEN);
        default: step_o = mk_dr(6'd16, {16'd0, PEN_KEY});
      endcase
      PH_ERASE: case (s)
        3'd0:    step_o = mk_ir(INS_PCMD);
        3'd1:    step_o = mk_cmd(15'h2380);
        3'd2:    step_o = mk_cmd(15'h3180);
        default: step_o = mk_cmd(15'h3380);
      endcase
      PH_EPOLL: step_o = mk_cmd(15'h3380);
      PH_WADDR: case (s)
        3'd0:    step_o = mk_ir(INS_PCMD);
        3'd1:    step_o = mk_cmd(15'h2310);
        3'd2:    step_o = mk_cmd(15'h0700 | {7'd0, addr_hi});
        default: step_o = mk_cmd(15'h0300 | {7'd0, addr_lo});
      endcase
      PH_WLOAD: step_o = first ? mk_ir(INS_PLOAD) : mk_dr(6'd8, {24'd0, byte_i});
      PH_WCOMMIT: case (s)
        3'd0:    step_o = mk_ir(INS_PCMD);
        3'd2:    step_o = mk_cmd(15'h3500);
        default: step_o = mk_cmd(15'h3700);
      endcase
      PH_WPOLL: step_o = mk_cmd(15'h3700);
      PH_LEAVE: case (s)
        3'd0:    step_o = mk_ir(INS_PCMD);
        3'd1:    step_o = mk_cmd(15'h2300);
        3'd2:    step_o = mk_cmd(15'h3300);
        3'd3:    step_o = mk_ir(INS_PEN);
        3'd4:    step_o = mk_dr(6'd16, 32'd0);
        3'd5:    step_o = mk_ir(INS_RST);
        default: step_o = mk_dr(6'd1, 32'd0);
      endcase
      default: step_o = mk_dr(6'd1, 32'd0);
    endcase
  end
endmodule

// File: rtl/jps_poll_ctr.sv
module jps_poll_ctr #(
  parameter int POLL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [POLL_W-1:0] limit_i,
  input  logic              clear_i,
  input  logic              tick_i,
  output logic              last_o
);
  logic [POLL_W-1:0] lim_q, cnt_q;
  logic [POLL_W:0]   eff_lim;

  assign eff_lim = (lim_q == '0) ? (POLL_W+1)'(1) : {1'b0, lim_q};
  assign last_o  = ({1'b0, cnt_q} + (POLL_W+1)'(1)) >= eff_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      lim_q <= limit_i;
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (tick_i && !last_o) begin
      cnt_q <= cnt_q + POLL_W'(1);
    end
  end

  a_r12_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < eff_lim);
endmodule

// File: rtl/jps_page_feed.sv
module jps_page_feed #(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = 17,
  parameter int LEN_W      = 18,
  parameter int IDX_W      = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              page_done_i,
  input  logic              load_active_i,
  input  logic [IDX_W-1:0]  pos_i,
  input  logic              take_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              remain_zero_o,
  output logic              last_page_o,
  output logic [7:0]        load_byte_o,
  output logic              byte_ready_o,
  output logic              stall_o
);
  localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, fill;
  logic [7:0]        byte_q;
  logic              have_q, need;

  assign fill          = (rem_q >= PAGE_L) ? PAGE_L : rem_q;
  assign need          = LEN_W'(pos_i) < fill;
  assign stall_o       = load_active_i && need && !have_q;
  assign byte_ready_o  = stall_o;
  assign load_byte_o   = need ? byte_q : 8'hFF;
  assign addr_o        = addr_q;
  assign remain_zero_o = (rem_q == '0);
  assign last_page_o   = (rem_q <= PAGE_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
      byte_q <= 8'h00;
      have_q <= 1'b0;
    end else if (start_i) begin
      addr_q <= offset_i;
      rem_q  <= len_i;
      have_q <= 1'b0;
    end else begin
      if (byte_valid_i && byte_ready_o) begin
        byte_q <= byte_data_i;
        have_q <= 1'b1;
      end else if (take_i) begin
        have_q <= 1'b0;
      end
      if (page_done_i) begin
        addr_q <= addr_q + ADDR_W'(PAGE_BYTES);
        rem_q  <= rem_q - fill;
      end
    end
  end

  a_r8_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !have_q);
  a_r11_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_done_i && !start_i |=> addr_q == $past(addr_q) + ADDR_W'(PAGE_BYTES));
endmodule

// File: rtl/jtag_prog_seq.sv
module jtag_prog_seq import jps_pkg::*; #(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = 17,
  parameter int LEN_W      = 18,
  parameter int POLL_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_offset_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [POLL_W-1:0] poll_max_i,
  output logic              cmd_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic [31:0]       id_o,
  output logic              sh_req_o,
  output logic              sh_ir_o,
  output logic [5:0]        sh_len_o,
  output logic [31:0]       sh_tdi_o,
  input  logic              sh_ack_i,
  input  logic [31:0]       sh_tdo_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int IDX_W  = $clog2(PAGE_BYTES + 2);

  logic             running_q, done_q;
  op_e              op_q;
  phase_e           phase_q, nxt_phase;
  logic [IDX_W-1:0] idx_q;
  err_e             err_q;
  logic [31:0]      id_q;

  step_t            step;
  logic             cmd_fire, misalign, ack, is_last, poll_phase, ready_seen, poll_last;
  logic             nxt_end, load_active, page_done, stall;
  logic             remain_zero, last_page;
  logic [ADDR_W-1:0] addr;
  logic [7:0]       load_byte;

  function automatic logic [IDX_W-1:0] phase_len(phase_e p);
    case (p)
      PH_ID:      return IDX_W'(2);
      PH_ENTER:   return IDX_W'(4);
      PH_ERASE:   return IDX_W'(5);
      PH_WADDR:   return IDX_W'(4);
      PH_WLOAD:   return IDX_W'(PAGE_BYTES + 1);
      PH_WCOMMIT: return IDX_W'(5);
      PH_LEAVE:   return IDX_W'(7);
      default:    return IDX_W'(1);
    endcase
  endfunction

  assign cmd_fire    = cmd_valid_i && !running_q;
  assign misalign    = (cmd_offset_i[PAGE_W-1:0] != '0);
  assign sh_req_o    = running_q && !stall;
  assign ack         = sh_req_o && sh_ack_i;
  assign is_last     = (idx_q == phase_len(phase_q) - IDX_W'(1));
  assign poll_phase  = (phase_q == PH_EPOLL) || (phase_q == PH_WPOLL);
  assign ready_seen  = sh_tdo_i[READY_BIT];
  assign load_active = running_q && (phase_q == PH_WLOAD) && (idx_q != '0);
  assign page_done   = ack && (phase_q == PH_WPOLL) && ready_seen;

  always_comb begin
    nxt_phase = phase_q;
    nxt_end   = 1'b0;
    case (phase_q)
      PH_ENTER: begin
        if (op_q == OP_WRITE) nxt_phase = remain_zero ? PH_LEAVE : PH_WADDR;
        else                  nxt_end   = 1'b1;
      end
      PH_ERASE:   nxt_phase = PH_EPOLL;
      PH_WADDR:   nxt_phase = PH_WLOAD;
      PH_WLOAD:   nxt_phase = PH_WCOMMIT;
      PH_WCOMMIT: nxt_phase = PH_WPOLL;
      PH_WPOLL:   nxt_phase = last_page ? PH_LEAVE : PH_WADDR;
      default:    nxt_end   = 1'b1;
    endcase
  end

  jps_step_rom #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rom (
    .phase_i (phase_q),
    .idx_i   (idx_q),
    .addr_i  (addr),
    .byte_i  (load_byte),
    .step_o  (step)
  );

  jps_poll_ctr #(.POLL_W(POLL_W)) u_poll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_fire),
    .limit_i (poll_max_i),
    .clear_i (ack && !poll_phase),
    .tick_i  (ack && poll_phase && !ready_seen),
    .last_o  (poll_last)
  );

  jps_page_feed #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_feed (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (cmd_fire),
    .offset_i      (cmd_offset_i),
    .len_i         (cmd_len_i),
    .page_done_i   (page_done),
    .load_active_i (load_active),
    .pos_i         (idx_q - IDX_W'(1)),
    .take_i        (ack && load_active),
    .byte_valid_i  (byte_valid_i),
    .byte_data_i   (byte_data_i),
    .addr_o        (addr),
    .remain_zero_o (remain_zero),
    .last_page_o   (last_page),
    .load_byte_o   (load_byte),
    .byte_ready_o  (byte_ready_o),
    .stall_o       (stall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      op_q      <= OP_READ_ID;
      phase_q   <= PH_ID;
      idx_q     <= '0;
      err_q     <= ERR_NONE;
      id_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (cmd_fire) begin
        op_q  <= op_e'(cmd_op_i);
        idx_q <= '0;
        err_q <= ERR_NONE;
        case (op_e'(cmd_op_i))
          OP_READ_ID: begin running_q <= 1'b1; phase_q <= PH_ID;    end
          OP_ENTER:   begin running_q <= 1'b1; phase_q <= PH_ENTER; end
          OP_ERASE:   begin running_q <= 1'b1; phase_q <= PH_ERASE; end
          OP_LEAVE:   begin running_q <= 1'b1; phase_q <= PH_LEAVE; end
          OP_WRITE: begin
            if (misalign) begin
              err_q  <= ERR_ALIGN;
              done_q <= 1'b1;
            end else begin
              running_q <= 1'b1;
              phase_q   <= PH_ENTER;
            end
          end
          default: done_q <= 1'b1;
        endcase
      end else if (ack) begin
        if (poll_phase && !ready_seen) begin
          if (poll_last) begin
            running_q <= 1'b0;
            done_q    <= 1'b1;
            err_q     <= ERR_TIMEOUT;
          end
        end else if (is_last) begin
          if (phase_q == PH_ID) begin
            id_q <= sh_tdo_i;
            if (sh_tdo_i[11:1] != MFG_CODE) err_q <= ERR_MFG;
          end
          if (nxt_end) begin
            running_q <= 1'b0;
            done_q    <= 1'b1;
          end else begin
            phase_q <= nxt_phase;
            idx_q   <= '0;
          end
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign cmd_ready_o = !running_q;
  assign busy_o      = running_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign id_o        = id_q;
  assign sh_ir_o     = step.ir;
  assign sh_len_o    = step.len;
  assign sh_tdi_o    = step.val;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sh_req_o && !byte_ready_o);
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_req_o && !sh_ack_i |=> sh_req_o && $stable(sh_ir_o) && $stable(sh_len_o) && $stable(sh_tdi_o));
  a_r2_ir_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_req_o && sh_ir_o |-> sh_len_o == IR_LEN);
  a_r13_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !sh_req_o);
  a_r10_align_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && (op_e'(cmd_op_i) == OP_WRITE) && misalign
    |=> done_o && !busy_o && (err_o == ERR_ALIGN));
endmodule

// File: tb/jtag_prog_seq_bench.sv
`timescale 1ns/1ps
module jtag_prog_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_op_i = 3'd0;
  logic [16:0] cmd_offset_i = '0;
  logic [17:0] cmd_len_i = '0;
  logic [15:0] poll_max_i = '0;
  logic        cmd_ready_o, busy_o, done_o;
  logic [1:0]  err_o;
  logic [31:0] id_o;
  logic        sh_req_o, sh_ir_o;
  logic [5:0]  sh_len_o;
  logic [31:0] sh_tdi_o;
  logic        sh_ack_i = 1'b0;
  logic [31:0] sh_tdo_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        byte_ready_o;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic        ir;
    logic [5:0]  len;
    logic [31:0] val;
    logic [31:0] tdo;
    string       tag;
  } exp_t;
  exp_t       exp_q[$];
  logic [7:0] byte_q[$];

  always #4 clk = ~clk;

  jtag_prog_seq u_jtag_prog_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_offset_i(cmd_offset_i),
    .cmd_len_i(cmd_len_i), .poll_max_i(poll_max_i),
    .cmd_ready_o(cmd_ready_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .id_o(id_o),
    .sh_req_o(sh_req_o), .sh_ir_o(sh_ir_o), .sh_len_o(sh_len_o), .sh_tdi_o(sh_tdi_o),
    .sh_ack_i(sh_ack_i), .sh_tdo_i(sh_tdo_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic ir, input logic [5:0] len, input logic [31:0] val,
                      input logic [31:0] tdo, input string tag);
    exp_t e;
    e.ir = ir; e.len = len; e.val = val; e.tdo = tdo; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_polls(input logic [31:0] word, input int n_busy, input bit ready, input string tag);
    for (int i = 0; i < n_busy; i++) push(0, 6'd15, word, 32'h0000_01FF, tag);
    if (ready) push(0, 6'd15, word, 32'h0000_0200, tag);
  endtask

  task automatic exp_enter();
    push(1, 6'd4, 32'hC, 0, "R4");  push(0, 6'd1, 32'h1, 0, "R4");
    push(1, 6'd4, 32'h4, 0, "R4");  push(0, 6'd16, 32'hA370, 0, "R4");
  endtask

  task automatic exp_leave();
    push(1, 6'd4, 32'h5, 0, "R5");  push(0, 6'd15, 32'h2300, 0, "R5");
    push(0, 6'd15, 32'h3300, 0, "R5");
    push(1, 6'd4, 32'h4, 0, "R5");  push(0, 6'd16, 32'h0, 0, "R5");
    push(1, 6'd4, 32'hC, 0, "R5");  push(0, 6'd1, 32'h0, 0, "R5");
  endtask

  task automatic exp_erase(input int n_busy, input bit ready);
    push(1, 6'd4, 32'h5, 0, "R6");
    push(0, 6'd15, 32'h2380, 0, "R6"); push(0, 6'd15, 32'h3180, 0, "R6");
    push(0, 6'd15, 32'h3380, 0, "R6"); push(0, 6'd15, 32'h3380, 0, "R6");
    push_polls(32'h3380, n_busy, ready, "R6");
  endtask

  task automatic exp_page(input logic [16:0] addr, input int nbytes, input logic [7:0] seed,
                          input int n_busy, input bit ready);
    logic [7:0] b;
    push(1, 6'd4, 32'h5, 0, "R7");
    push(0, 6'd15, 32'h2310, 0, "R7");
    push(0, 6'd15, 32'h0700 | {24'd0, 8'(addr >> 9)}, 0, "R7");
    push(0, 6'd15, 32'h0300 | {24'd0, 8'(addr >> 1)}, 0, "R7");
    push(1, 6'd4, 32'h6, 0, "R8");
    for (int k = 0; k < 256; k++) begin
      if (k < nbytes) begin
        b = 8'(seed + 8'(k * 7));
        byte_q.push_back(b);
      end else begin
        b = 8'hFF;
      end
      push(0, 6'd8, {24'd0, b}, 0, "R8");
    end
    push(1, 6'd4, 32'h5, 0, "R9");
    push(0, 6'd15, 32'h3700, 0, "R9"); push(0, 6'd15, 32'h3500, 0, "R9");
    push(0, 6'd15, 32'h3700, 0, "R9"); push(0, 6'd15, 32'h3700, 0, "R9");
    push_polls(32'h3700, n_busy, ready, "R9");
  endtask

  // Scoreboard monitor doubling as shift engine model
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      sh_ack_i = 1'b0;
      if (rst_n && sh_req_o) begin
        if (exp_q.size() == 0) begin
          check(0, "R1", "unexpected shift", {25'd0, sh_ir_o, sh_len_o, sh_tdi_o}, 64'd0);
          sh_tdo_i = 32'h0000_0200;
        end else begin
          e = exp_q.pop_front();
          check(sh_ir_o == e.ir && sh_len_o == e.len && sh_tdi_o == e.val, e.tag, "shift",
                {25'd0, sh_ir_o, sh_len_o, sh_tdi_o}, {25'd0, e.ir, e.len, e.val});
          sh_tdo_i = e.tdo;
        end
        sh_ack_i = 1'b1;
      end
    end
  end

  // Byte stream driver
  initial begin
    bit took = 0;
    logic [7:0] dummy;
    forever begin
      @(negedge clk);
      if (took) dummy = byte_q.pop_front();
      byte_valid_i = (byte_q.size() > 0);
      byte_data_i  = (byte_q.size() > 0) ? byte_q[0] : 8'h00;
      #3;
      took = byte_valid_i && byte_ready_o;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R13 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  task automatic run_cmd(input logic [2:0] op, input logic [16:0] off, input logic [17:0] len,
                         input logic [15:0] pm, input logic [1:0] exp_err, input string tag);
    int n;
    check(cmd_ready_o == 1'b1, "R1", "ready before command", {63'd0, cmd_ready_o}, 64'd1);
    cmd_op_i = op; cmd_offset_i = off; cmd_len_i = len; poll_max_i = pm;
    cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done_o == 1'b1, "R13", "done seen", {63'd0, done_o}, 64'd1);
    check(busy_o == 1'b0, "R13", "busy low at done", {63'd0, busy_o}, 64'd0);
    check(err_o == exp_err, tag, "error code", {62'd0, err_o}, {62'd0, exp_err});
    @(negedge clk);
    check(done_o == 1'b0, "R13", "done one cycle", {63'd0, done_o}, 64'd0);
    check(exp_q.size() == 0, tag, "shifts left over", 64'(exp_q.size()), 64'd0);
    check(byte_q.size() == 0, "R8", "bytes left over", 64'(byte_q.size()), 64'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy_o == 0, "R1", "busy after reset", {63'd0, busy_o}, 0);
    check(cmd_ready_o == 1, "R1", "ready after reset", {63'd0, cmd_ready_o}, 1);
    check(sh_req_o == 0 && byte_ready_o == 0, "R1", "quiet after reset",
          {62'd0, sh_req_o, byte_ready_o}, 0);
    check(done_o == 0 && err_o == 0, "R1", "status after reset", {61'd0, done_o, err_o}, 0);

    // R3 good identification word
    push(1, 6'd4, 32'h1, 0, "R3");
    push(0, 6'd32, 32'h0, 32'h3970_203F, "R3");
    run_cmd(3'd0, 0, 0, 16'd4, 2'd0, "R3");
    check(id_o[27:12] == 16'h9702, "R3", "part field", 64'(id_o[27:12]), 64'h9702);
    check(id_o[31:28] == 4'h3, "R3", "revision field", 64'(id_o[31:28]), 64'h3);

    // R3 wrong manufacturer
    push(1, 6'd4, 32'h1, 0, "R3");
    push(0, 6'd32, 32'h0, 32'h1123_403D, "R3");
    run_cmd(3'd0, 0, 0, 16'd4, 2'd3, "R3");
    check(id_o[27:12] == 16'h1234, "R3", "part field bad mfg", 64'(id_o[27:12]), 64'h1234);

    // R4 enter, R6 erase with three busy polls, R5 leave
    exp_enter();
    run_cmd(3'd1, 0, 0, 16'd4, 2'd0, "R4");
    exp_erase(3, 1);
    run_cmd(3'd2, 0, 0, 16'd10, 2'd0, "R6");
    exp_leave();
    run_cmd(3'd4, 0, 0, 16'd4, 2'd0, "R5");

    // R10 misaligned write
    run_cmd(3'd3, 17'h00080, 18'd4, 16'd4, 2'd1, "R10");

    // R11 two pages, second partial (R8 padding), stray command while busy (R1)
    exp_enter();
    exp_page(17'h00200, 256, 8'h11, 1, 1);
    exp_page(17'h00300, 44, 8'h5A, 0, 1);
    exp_leave();
    fork
      run_cmd(3'd3, 17'h00200, 18'd300, 16'd5, 2'd0, "R11");
      begin
        repeat (20) @(negedge clk);
        check(cmd_ready_o == 0 && busy_o == 1, "R1", "busy mid write",
              {62'd0, cmd_ready_o, busy_o}, 64'd1);
        cmd_op_i = 3'd2;
        cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
      end
    join

    // R12 commit polling exhausted at limit 2, top address bytes (R7)
    exp_enter();
    exp_page(17'h1FF00, 10, 8'h33, 2, 0);
    run_cmd(3'd3, 17'h1FF00, 18'd10, 16'd2, 2'd2, "R12");

    // R12 erase with limit 0 behaves as a single poll
    exp_erase(1, 0);
    run_cmd(3'd2, 0, 0, 16'd0, 2'd2, "R12");

    // R11 exact single full page
    exp_enter();
    exp_page(17'h00000, 256, 8'h77, 0, 1);
    exp_leave();
    run_cmd(3'd3, 17'h00000, 18'd256, 16'd3, 2'd0, "R11");

    summary();
    $finish;
  end
endmodule